// File: doc/BRIEF.md
# Single-Cycle Transfer-Set Executor

This block runs one instruction per clock. An instruction is a set of source-to-destination moves among a small file of storage endpoints: seven general registers, an instruction counter, an accumulator, two same-cycle bus nodes, an ALU input that can only be written, and two read-only sources. The read-only sources are the ALU result and the operand taken from the current instruction. An instruction carries two alternative move sets, called forks, and a condition selector. The selector names one flag, and that flag's value picks the fork that runs.

Register endpoints give every reader in a cycle the value they held when the cycle began. A value written to them becomes visible one cycle later, so swaps and rotations need no temporary. Bus nodes and the ALU result resolve combinationally inside the cycle, and a chain through them delivers its data in the same cycle. A bus node read without a writer in that cycle is illegal. The instruction counter never steps on its own; it moves only on an explicit load or increment.

Any illegal set raises a one-cycle error indication, and that cycle commits nothing. Illegal sets include a repeated destination, a bad code, a read of an unwritten bus or ALU result, and a loop among bus nodes. Move sets normally arrive as one source field per destination. A request-list form is also accepted, in which a repeated destination can be expressed and is therefore caught.

Top module: `rtx_core`

## Requirements
- R1: A general register read as a source returns its value from the start of the cycle, even when the same cycle writes it. The new value appears at the outputs after the clock edge. Rotations and swaps therefore exchange the old values.
- R2: A chain of bus moves resolves within one cycle. For example, reg0 to bus 0, bus 0 to bus 1, bus 1 to reg3 leaves reg0's old value in reg3 after the edge.
- R3: A set that reads a bus node with no writer in the same set is illegal. A set in which bus nodes feed each other in a loop is also illegal. In either case `illegal_o` is 1 during that cycle and no register, counter or accumulator changes.
- R4: When `list_mode` is 1, two requests naming the same destination make the set illegal, with no state change. Request k sits in bits [8k+7:8k], with the destination in the upper nibble and the source in the lower nibble. Destination 0 marks an empty request, and a request with a nonzero destination and source 0 is illegal.
- R5: When `cond_sel` is 0, fork 0 runs. When `cond_sel` is n (1 to 3), the fork that runs is flags[n-1]: 0 selects fork 0 and 1 selects fork 1.
- R6: The counter changes only on a move into code 8 or on the running fork's increment bit. The increment wraps from 0xFFFF to 0. A set with no counter load and no increment leaves the counter unchanged. Load and increment together are illegal.
- R7: The ALU result (code 14) equals X op Y. X is the value moved into the accumulator this cycle if there is one, otherwise the stored accumulator. Y is the value moved into the ALU input. The op codes are 0 for X+Y, 1 for X−Y, 2 for X&Y and 3 for X^Y. Reading the result with no ALU-input move, or feeding the result back into the accumulator operand, is illegal. The accumulator stores the value moved into it.
- R8: The operand source (code 13) returns `opnd_i` in the same cycle. Several code uses are illegal: code 12 or code 15 used as a source, and code 13, 14 or 15 used as a list destination.
- R9: While `rst` is high at a clock edge, all registers, the counter and the accumulator clear to 0.
- R10: The endpoint codes are: 0 none, 1–7 general registers 0–6, 8 counter, 9 accumulator, 10 bus 0, 11 bus 1, 12 ALU input, 13 operand, 14 ALU result, 15 illegal. In field mode, the source selected for destination code d sits in bits [4d−1:4d−4] of the fork's move word, and a field value of 0 means no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| list_mode | input | 1 | 1: move words use the request-list form |
| cond_sel | input | 2 | Condition selector; 0 means always fork 0 |
| flags | input | 3 | Condition flags |
| opnd_i | input | 16 | Operand of the current instruction |
| f0_xfer | input | 48 | Fork 0 move word |
| f0_inc | input | 1 | Fork 0 counter increment |
| f0_op | input | 2 | Fork 0 ALU operation |
| f1_xfer | input | 48 | Fork 1 move word |
| f1_inc | input | 1 | Fork 1 counter increment |
| f1_op | input | 2 | Fork 1 ALU operation |
| gpr_flat | output | 112 | General registers; register g at bits [16g+15:16g] |
| ic_q | output | 16 | Instruction counter |
| acc_q | output | 16 | Accumulator |
| illegal_o | output | 1 | Current set is illegal; nothing commits |

## Verification
The general registers are first filled with distinct operand values. All six non-trivial rotations of the register file then run, and these would expose any read that saw a same-cycle write, since every register changes at once. Bus chains are written in scrambled field order, together with a mixed bus/register swap, to separate true same-cycle resolution from evaluation in field order. The full sweep of selector and flag values (32 cases) confirms that each fork follows exactly its named flag. Four further sets separate the ALU operand taken from a same-cycle accumulator move from the stored one. The error cases cover an unwritten bus, a bus loop, a duplicate list entry, bad codes, a result loop and a counter load/increment clash, and each case also carries a legal move that must not commit.

// File: rtl/rtx_pkg.sv
`timescale 1ns/1ps
package rtx_pkg;

   typedef enum logic [1:0] {
      ALU_ADD = 2'd0,
      ALU_SUB = 2'd1,
      ALU_AND = 2'd2,
      ALU_XOR = 2'd3
   } alu_op_e;

endpackage

// File: rtl/rtx_decode.sv
`timescale 1ns/1ps
// Turns one fork's move word into a source selector per destination.
module rtx_decode #(
   parameter int NGPR    = 7,
   parameter int NBUS    = 2,
   parameter bit LIST_EN = 1'b1,
   localparam int C_AIN  = NGPR + NBUS + 3,
   localparam int C_RES  = C_AIN + 2,
   localparam int NDST   = C_AIN,
   localparam int SW     = $clog2(C_RES + 1),
   localparam int XW     = NDST * SW,
   localparam int NREQ   = XW / (2 * SW)
) (
   input  logic                     list_mode,
   input  logic [XW-1:0]            xfer,
   output logic [NDST-1:0][SW-1:0]  sel,
   output logic                     bad,
   output logic                     dup
);

   logic [NDST-1:0][SW-1:0] sel_f, sel_l;
   logic                    bad_f, bad_l, dup_l;

   // field form: destination code d owns slice d-1
   for (genvar d = 0; d < NDST; d++) begin : g_field
      assign sel_f[d] = xfer[d*SW +: SW];
   end

   always_comb begin
      bad_f = 1'b0;
      for (int d = 0; d < NDST; d++) begin
         if (sel_f[d] == SW'(C_AIN) || sel_f[d] > SW'(C_RES)) bad_f = 1'b1;
      end
   end

   if (LIST_EN) begin : g_list
      always_comb begin
         logic [SW-1:0] dcode, scode;
         sel_l = '0;
         bad_l = 1'b0;
         dup_l = 1'b0;
         for (int k = 0; k < NREQ; k++) begin
            dcode = xfer[k*2*SW + SW +: SW];
            scode = xfer[k*2*SW +: SW];
            if (dcode != '0) begin
               if (dcode > SW'(NDST)) begin
                  bad_l = 1'b1;
               end else if (scode == '0 || scode == SW'(C_AIN) || scode > SW'(C_RES)) begin
                  bad_l = 1'b1;
               end else begin
                  for (int d = 0; d < NDST; d++) begin
                     if (dcode == SW'(d + 1)) begin
                        if (sel_l[d] != '0) dup_l = 1'b1;
                        sel_l[d] = scode;
                     end
                  end
               end
            end
         end
      end
   end else begin : g_nolist
      assign sel_l = '0;
      assign bad_l = 1'b0;
      assign dup_l = 1'b0;
   end

   logic use_l;
   assign use_l = list_mode & LIST_EN;
   assign sel   = use_l ? sel_l : sel_f;
   assign bad   = use_l ? bad_l : bad_f;
   assign dup   = use_l & dup_l;

endmodule

// File: rtl/rtx_resolve.sv
`timescale 1ns/1ps
// Resolves every selected source to a value within the cycle.
// Bus nodes and the ALU result settle by unrolled relaxation.
module rtx_resolve
   import rtx_pkg::*;
#(
   parameter int DW      = 16,
   parameter int NGPR    = 7,
   parameter int NBUS    = 2,
   localparam int C_GPR0 = 1,
   localparam int C_IC   = NGPR + 1,
   localparam int C_ACC  = NGPR + 2,
   localparam int C_BUS0 = NGPR + 3,
   localparam int C_AIN  = NGPR + NBUS + 3,
   localparam int C_OPND = C_AIN + 1,
   localparam int C_RES  = C_AIN + 2,
   localparam int NDST   = C_AIN,
   localparam int NREG   = NGPR + 2,
   localparam int SW     = $clog2(C_RES + 1),
   localparam int NST    = NBUS + 1
) (
   input  logic [NDST-1:0][SW-1:0]  sel,
   input  alu_op_e                  op,
   input  logic [NGPR-1:0][DW-1:0]  gpr,
   input  logic [DW-1:0]            ic,
   input  logic [DW-1:0]            acc,
   input  logic [DW-1:0]            opnd,
   output logic [NREG-1:0][DW-1:0]  rval,
   output logic                     unres
);

   typedef struct packed {
      logic          ok;
      logic [DW-1:0] v;
   } fetch_t;

   function automatic fetch_t fetch(
      input logic [SW-1:0]             c,
      input logic [NGPR-1:0][DW-1:0]   g,
      input logic [DW-1:0]             icv,
      input logic [DW-1:0]             accv,
      input logic [DW-1:0]             opv,
      input fetch_t [NBUS-1:0]         bv,
      input fetch_t                    rv);
      fetch_t r;
      r = '0;
      for (int i = 0; i < NGPR; i++)
         if (c == SW'(C_GPR0 + i)) r = '{ok: 1'b1, v: g[i]};
      if (c == SW'(C_IC))   r = '{ok: 1'b1, v: icv};
      if (c == SW'(C_ACC))  r = '{ok: 1'b1, v: accv};
      for (int b = 0; b < NBUS; b++)
         if (c == SW'(C_BUS0 + b)) r = bv[b];
      if (c == SW'(C_OPND)) r = '{ok: 1'b1, v: opv};
      if (c == SW'(C_RES))  r = rv;
      return r;
   endfunction

   function automatic logic [DW-1:0] alu(input alu_op_e o, input logic [DW-1:0] x, input logic [DW-1:0] y);
      case (o)
         ALU_ADD: return x + y;
         ALU_SUB: return x - y;
         ALU_AND: return x & y;
         default: return x ^ y;
      endcase
   endfunction

   fetch_t [NBUS-1:0] bcur, bnxt;
   fetch_t            rcur, rnxt, aop, ain, fin;

   always_comb begin
      bcur  = '0;
      bnxt  = '0;
      rcur  = '0;
      rnxt  = '0;
      aop   = '0;
      ain   = '0;
      fin   = '0;
      unres = 1'b0;
      rval  = '0;
      // each pass lets one more link of any acyclic chain settle
      for (int s = 0; s < NST; s++) begin
         for (int b = 0; b < NBUS; b++)
            bnxt[b] = fetch(sel[C_BUS0-1+b], gpr, ic, acc, opnd, bcur, rcur);
         if (sel[C_ACC-1] != '0)
            aop = fetch(sel[C_ACC-1], gpr, ic, acc, opnd, bcur, rcur);
         else
            aop = '{ok: 1'b1, v: acc};
         ain  = fetch(sel[C_AIN-1], gpr, ic, acc, opnd, bcur, rcur);
         rnxt = '{ok: aop.ok & ain.ok, v: alu(op, aop.v, ain.v)};
         bcur = bnxt;
         rcur = rnxt;
      end
      for (int d = 0; d < NDST; d++) begin
         fin = fetch(sel[d], gpr, ic, acc, opnd, bcur, rcur);
         if (sel[d] != '0 && !fin.ok) unres = 1'b1;
         if (d < NREG) rval[d] = fin.v;
      end
   end

endmodule

// File: rtl/rtx_core.sv
`timescale 1ns/1ps
module rtx_core
   import rtx_pkg::*;
#(
   parameter int DW      = 16,
   parameter int NGPR    = 7,
   parameter int NBUS    = 2,
   parameter int NFLAG   = 3,
   parameter bit LIST_EN = 1'b1,
   localparam int C_IC   = NGPR + 1,
   localparam int C_ACC  = NGPR + 2,
   localparam int C_AIN  = NGPR + NBUS + 3,
   localparam int C_OPND = C_AIN + 1,
   localparam int C_RES  = C_AIN + 2,
   localparam int NDST   = C_AIN,
   localparam int NREG   = NGPR + 2,
   localparam int SW     = $clog2(C_RES + 1),
   localparam int XW     = NDST * SW,
   localparam int FSW    = $clog2(NFLAG + 1)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 list_mode,
   input  logic [FSW-1:0]       cond_sel,
   input  logic [NFLAG-1:0]     flags,
   input  logic [DW-1:0]        opnd_i,
   input  logic [XW-1:0]        f0_xfer,
   input  logic                 f0_inc,
   input  logic [1:0]           f0_op,
   input  logic [XW-1:0]        f1_xfer,
   input  logic                 f1_inc,
   input  logic [1:0]           f1_op,
   output logic [NGPR*DW-1:0]   gpr_flat,
   output logic [DW-1:0]        ic_q,
   output logic [DW-1:0]        acc_q,
   output logic                 illegal_o
);

   // elaboration-time parameter checks
   if (DW < 2)    begin : g_chk_dw   $error("DW must be at least 2");   end
   if (NGPR < 2)  begin : g_chk_gpr  $error("NGPR must be at least 2"); end
   if (NBUS < 1)  begin : g_chk_bus  $error("NBUS must be at least 1"); end
   if (NFLAG < 1) begin : g_chk_flag $error("NFLAG must be at least 1"); end

   // ---------------- fork choice ----------------
   logic fork_hi;
   always_comb begin
      fork_hi = 1'b0;
      for (int i = 0; i < NFLAG; i++)
         if (cond_sel == FSW'(i + 1)) fork_hi = flags[i];
   end

   logic [XW-1:0] xfer_sel;
   logic          inc_sel;
   alu_op_e       op_sel;
   assign xfer_sel = fork_hi ? f1_xfer : f0_xfer;
   assign inc_sel  = fork_hi ? f1_inc  : f0_inc;
   assign op_sel   = alu_op_e'(fork_hi ? f1_op : f0_op);

   // ---------------- decode and resolve ----------------
   logic [NDST-1:0][SW-1:0] sel;
   logic                    dec_bad, dec_dup, unres;
   logic [NREG-1:0][DW-1:0] rval;
   logic [NGPR-1:0][DW-1:0] gpr_r;
   logic [DW-1:0]           ic_r, acc_r;

   rtx_decode #(.NGPR(NGPR), .NBUS(NBUS), .LIST_EN(LIST_EN)) i_decode (
      .list_mode (list_mode),
      .xfer      (xfer_sel),
      .sel       (sel),
      .bad       (dec_bad),
      .dup       (dec_dup)
   );

   rtx_resolve #(.DW(DW), .NGPR(NGPR), .NBUS(NBUS)) i_resolve (
      .sel   (sel),
      .op    (op_sel),
      .gpr   (gpr_r),
      .ic    (ic_r),
      .acc   (acc_r),
      .opnd  (opnd_i),
      .rval  (rval),
      .unres (unres)
   );

   logic ic_clash, commit;
   assign ic_clash  = inc_sel && (sel[C_IC-1] != '0);
   assign illegal_o = dec_bad | dec_dup | unres | ic_clash;
   assign commit    = !illegal_o;

   // ---------------- state ----------------
   for (genvar g = 0; g < NGPR; g++) begin : g_gpr
      always_ff @(posedge clk) begin
         if (rst)                           gpr_r[g] <= '0;
         else if (commit && sel[g] != '0)   gpr_r[g] <= rval[g];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ic_r  <= '0;
         acc_r <= '0;
      end else if (commit) begin
         if (sel[C_IC-1] != '0) ic_r <= rval[C_IC-1];
         else if (inc_sel)      ic_r <= ic_r + DW'(1);
         if (sel[C_ACC-1] != '0) acc_r <= rval[C_ACC-1];
      end
   end

   assign gpr_flat = gpr_r;
   assign ic_q     = ic_r;
   assign acc_q    = acc_r;

   // ---------------- assertions ----------------
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (gpr_flat == '0 && ic_q == '0 && acc_q == '0)); // R9

   AST_ERROR_FREEZES: assert property (@(posedge clk) disable iff (rst)
      illegal_o |=> (gpr_flat == $past(gpr_flat) && ic_q == $past(ic_q) && acc_q == $past(acc_q))); // R3

   AST_IC_STILL: assert property (@(posedge clk) disable iff (rst)
      (commit && !inc_sel && sel[C_IC-1] == '0) |=> ic_q == $past(ic_q)); // R6

   AST_IC_STEP: assert property (@(posedge clk) disable iff (rst)
      (commit && inc_sel) |=> ic_q == $past(ic_q) + DW'(1)); // R6

   AST_OPND_LOAD: assert property (@(posedge clk) disable iff (rst)
      (commit && sel[0] == SW'(C_OPND)) |=> gpr_r[0] == $past(opnd_i)); // R8

   for (genvar gd = 0; gd < NGPR; gd++) begin : g_ast_dst
      for (genvar gs = 0; gs < NGPR; gs++) begin : g_ast_src
         AST_REG_SNAPSHOT: assert property (@(posedge clk) disable iff (rst)
            (commit && sel[gd] == SW'(gs + 1)) |=> gpr_r[gd] == $past(gpr_r[gs])); // R1
      end
   end

endmodule

// File: tb/test_rtx_core.sv
`timescale 1ns/1ps
module test_rtx_core;

   localparam int CG0 = 1, CIC = 8, CACC = 9, CB1 = 10, CB2 = 11;
   localparam int CAIN = 12, COPND = 13, CRES = 14;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        list_mode;
   logic [1:0]  cond_sel;
   logic [2:0]  flags;
   logic [15:0] opnd_i;
   logic [47:0] f0_xfer, f1_xfer;
   logic        f0_inc, f1_inc;
   logic [1:0]  f0_op, f1_op;
   logic [111:0] gpr_flat;
   logic [15:0] ic_q, acc_q;
   logic        illegal_o;

   int n_cmp = 0;
   int n_bad = 0;
   logic [15:0] m_g [7];
   logic [15:0] m_ic, m_acc;

   always #4 clk = ~clk;

   rtx_core i_rtx_core (
      .clk(clk), .rst(rst), .list_mode(list_mode), .cond_sel(cond_sel), .flags(flags),
      .opnd_i(opnd_i), .f0_xfer(f0_xfer), .f0_inc(f0_inc), .f0_op(f0_op),
      .f1_xfer(f1_xfer), .f1_inc(f1_inc), .f1_op(f1_op),
      .gpr_flat(gpr_flat), .ic_q(ic_q), .acc_q(acc_q), .illegal_o(illegal_o)
   );

   function automatic logic [47:0] put(input logic [47:0] w, input int dst, input int src);
      w[(dst-1)*4 +: 4] = 4'(src);
      return w;
   endfunction

   function automatic logic [47:0] lput(input logic [47:0] w, input int k, input int dst, input int src);
      w[k*8 +: 8] = {4'(dst), 4'(src)};
      return w;
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      for (int g = 0; g < 7; g++) chk(tag, gpr_flat[g*16 +: 16], m_g[g]);
      chk(tag, ic_q, m_ic);
      chk(tag, acc_q, m_acc);
   endtask

   task automatic clr_in();
      list_mode = 1'b0; cond_sel = 2'd0; flags = 3'd0; opnd_i = 16'd0;
      f0_xfer = '0; f0_inc = 1'b0; f0_op = 2'd0;
      f1_xfer = '0; f1_inc = 1'b0; f1_op = 2'd0;
   endtask

   // inputs are set by the caller; error is sampled mid-low phase,
   // state one time unit after the committing edge
   task automatic step(input string tag, input bit exp_err);
      @(negedge clk);
      chk({tag, " err"}, {15'd0, illegal_o}, {15'd0, exp_err});
      @(posedge clk);
      #1;
      check_all(tag);
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: run did not end actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] nm [7];
      logic [15:0] a, b, r;
      int fk;
      clr_in();
      for (int g = 0; g < 7; g++) m_g[g] = 16'd0;
      m_ic = 16'd0; m_acc = 16'd0;
      rst = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;
      check_all("R9 reset state");

      // R8 R10: fill registers from the operand source
      for (int g = 0; g < 7; g++) begin
         clr_in();
         opnd_i  = 16'(g * 16'h2301 + 16'h0a5c);
         f0_xfer = put('0, CG0 + g, COPND);
         m_g[g]  = opnd_i;
         step("R8 R10 operand load", 1'b0);
      end

      // R1: every non-trivial rotation of the register file
      for (int k = 1; k < 7; k++) begin
         clr_in();
         for (int g = 0; g < 7; g++) begin
            f0_xfer = put(f0_xfer, CG0 + g, CG0 + (g + k) % 7);
            nm[g] = m_g[(g + k) % 7];
         end
         for (int g = 0; g < 7; g++) m_g[g] = nm[g];
         step("R1 rotate", 1'b0);
      end

      // R1: swap plus a third reader of an overwritten register
      clr_in();
      f0_xfer = put(put(put('0, CG0 + 0, CG0 + 1), CG0 + 1, CG0 + 0), CG0 + 2, CG0 + 0);
      a = m_g[0]; b = m_g[1];
      m_g[0] = b; m_g[1] = a; m_g[2] = a;
      step("R1 swap", 1'b0);

      // R2: bus chains
      clr_in();
      f0_xfer = put(put(put(put('0, CG0 + 3, CB2), CB2, CB1), CB1, CG0 + 0), CG0 + 4, CB2);
      m_g[3] = m_g[0]; m_g[4] = m_g[0];
      step("R2 bus chain reg", 1'b0);

      clr_in();
      opnd_i  = 16'hbeef;
      f0_xfer = put(put(put(put('0, CB1, CB2), CB2, COPND), CG0 + 5, CB1), CG0 + 6, CB2);
      m_g[5] = 16'hbeef; m_g[6] = 16'hbeef;
      step("R2 bus chain operand", 1'b0);

      clr_in();
      f0_xfer = put(put(put('0, CG0 + 0, CB1), CB1, CG0 + 1), CG0 + 1, CG0 + 0);
      a = m_g[0]; b = m_g[1];
      m_g[0] = b; m_g[1] = a;
      step("R2 bus swap", 1'b0);

      // R3: unwritten bus read and bus loop, each with a legal move aside
      clr_in();
      opnd_i  = 16'h7777;
      f0_xfer = put(put('0, CG0 + 0, CB1), CG0 + 5, COPND);
      step("R3 unwritten bus", 1'b1);

      clr_in();
      opnd_i  = 16'h7777;
      f0_xfer = put(put(put(put('0, CB1, CB2), CB2, CB1), CG0 + 2, CB1), CG0 + 5, COPND);
      step("R3 bus loop", 1'b1);

      // R4: list form
      clr_in();
      list_mode = 1'b1;
      f0_xfer = lput(lput('0, 0, CG0 + 2, CG0 + 3), 4, CG0 + 3, CG0 + 2);
      a = m_g[2]; b = m_g[3];
      m_g[2] = b; m_g[3] = a;
      step("R4 list legal swap", 1'b0);

      clr_in();
      list_mode = 1'b1;
      opnd_i  = 16'h1234;
      f0_xfer = lput(lput(lput('0, 0, CG0 + 1, CG0 + 0), 3, CG0 + 4, COPND), 5, CG0 + 1, CG0 + 2);
      step("R4 list duplicate", 1'b1);

      clr_in();
      list_mode = 1'b1;
      f0_xfer = lput('0, 1, CG0 + 4, 0);
      step("R4 list empty source", 1'b1);

      // R8: illegal codes
      clr_in();
      list_mode = 1'b1;
      f0_xfer = lput(lput('0, 0, COPND, CG0 + 0), 1, CG0 + 6, CG0 + 0);
      step("R8 list operand dest", 1'b1);

      clr_in();
      f0_xfer = put(put('0, CG0 + 0, CAIN), CG0 + 6, CG0 + 1);
      step("R8 ALU input as source", 1'b1);

      clr_in();
      f0_xfer = put('0, CG0 + 3, 15);
      step("R8 code 15 source", 1'b1);

      // R5: every selector and flag combination
      for (int s = 0; s < 4; s++) begin
         for (int f = 0; f < 8; f++) begin
            clr_in();
            cond_sel = 2'(s);
            flags    = 3'(f);
            opnd_i   = 16'(s * 64 + f * 5 + 7);
            f0_xfer  = put('0, CG0 + 5, COPND);
            f1_xfer  = put('0, CG0 + 6, COPND);
            fk = (s == 0) ? 0 : ((f >> (s - 1)) & 1);
            if (fk == 1) m_g[6] = opnd_i; else m_g[5] = opnd_i;
            step("R5 fork choice", 1'b0);
         end
      end

      // R6: counter
      clr_in();
      step("R6 idle holds counter", 1'b0);
      clr_in();
      f0_inc = 1'b1; m_ic = m_ic + 16'd1;
      step("R6 increment", 1'b0);
      clr_in();
      opnd_i = 16'h0040; f0_xfer = put('0, CIC, COPND); m_ic = 16'h0040;
      step("R6 load", 1'b0);
      clr_in();
      cond_sel = 2'd1; flags = 3'b001; opnd_i = 16'h0100;
      f0_xfer = put('0, CIC, COPND); f1_inc = 1'b1; m_ic = m_ic + 16'd1;
      step("R6 branch not taken", 1'b0);
      clr_in();
      cond_sel = 2'd1; flags = 3'b000; opnd_i = 16'h0100;
      f0_xfer = put('0, CIC, COPND); f1_inc = 1'b1; m_ic = 16'h0100;
      step("R6 branch taken", 1'b0);
      clr_in();
      opnd_i = 16'h0200; f0_xfer = put('0, CIC, COPND); f0_inc = 1'b1;
      step("R6 load and increment clash", 1'b1);
      clr_in();
      opnd_i = 16'hffff; f0_xfer = put('0, CIC, COPND); m_ic = 16'hffff;
      step("R6 load top", 1'b0);
      clr_in();
      f0_inc = 1'b1; m_ic = 16'h0000;
      step("R6 increment wraps", 1'b0);

      // R7: accumulator and ALU
      for (int o = 0; o < 4; o++) begin
         clr_in();
         f0_op   = 2'(o);
         f0_xfer = put(put(put('0, CACC, CG0 + 1), CAIN, CG0 + 0), CG0 + 1, CRES);
         a = m_g[1]; b = m_g[0];
         case (o)
            0: r = a + b;
            1: r = a - b;
            2: r = a & b;
            default: r = a ^ b;
         endcase
         m_acc = a; m_g[1] = r;
         step("R7 alu op with accumulator move", 1'b0);
      end

      clr_in();
      opnd_i  = 16'h0123;
      f0_xfer = put(put('0, CAIN, COPND), CG0 + 2, CRES);
      m_g[2]  = m_acc + 16'h0123;
      step("R7 stored accumulator operand", 1'b0);

      clr_in();
      f0_op   = 2'd3;
      f0_xfer = put(put(put('0, CAIN, CB1), CB1, CG0 + 3), CG0 + 4, CRES);
      m_g[4]  = m_acc ^ m_g[3];
      step("R7 result through bus", 1'b0);

      clr_in();
      f0_xfer = put('0, CG0 + 0, CRES);
      step("R7 result without input", 1'b1);

      clr_in();
      f0_xfer = put(put('0, CACC, CRES), CAIN, CG0 + 0);
      step("R7 result loop", 1'b1);

      // R9: reset after activity
      clr_in();
      rst = 1'b1;
      @(posedge clk);
      #1;
      rst = 1'b0;
      for (int g = 0; g < 7; g++) m_g[g] = 16'd0;
      m_ic = 16'd0; m_acc = 16'd0;
      check_all("R9 reset clears");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule